// File: doc/BRIEF.md
# DMA Channel Register Bank

This block holds the four 32-bit software-visible words of a storage controller's DMA channel. A simple word-addressed bus writes and reads them. Word 0 is the control and status word and word 1 holds the DMA address. Words 2 and 3 are plain storage. Reads have no side effects and return the stored word directly.

A write to the control word is not stored as given. The top nibble is forced to a fixed version code. A zero write is replaced by a flush flag. A flush request is dropped unless a reset is also requested. Setting the reset bit pulses a reset request to the attached controller and wipes the other words. Writing the address word stores it and also replaces the control word with an "address loaded" marker.

The attached controller reports interrupt events and acknowledgements. The block keeps a pending bit in the control word and drives the interrupt output from it. Bus writes, events and acknowledgements in the same cycle are merged so that none is lost.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset all four words read zero, and `irq` and `ctl_reset_req` are low.
- R2: The word index is address bits [3:2]; other address bits are ignored. Words 2 and 3 read back exactly what was written.
- R3: Every control-word (index 0) write stores the value with bits [31:28] replaced by 4'hA.
- R4: A control write with bit 7 set drives `ctl_reset_req` high for exactly the next cycle and clears words 1 to 3. The control word still stores the written value with bit 6 kept and the nibble forced.
- R5: A control write with bit 7 clear and bit 6 set stores bit 6 as zero.
- R6: A control write of exactly zero stores 32'hA000_0040.
- R7: A write to word 1 stores the address and replaces the control word with 32'h0400_0000.
- R8: An `irq_event` pulse sets control bit 0 and raises `irq` on the next cycle.
- R9: An `irq_ack` pulse clears control bit 0 and lowers `irq` on the next cycle.
- R10: A control write with bit 4 (interrupt enable) clear lowers `irq`. With bit 4 set, `irq` keeps its value. Control bit 0 then follows the written value.
- R11: Same-cycle merging is applied in a fixed order: the write result first, then the acknowledge clear, then the event set. An event therefore always leaves bit 0 and `irq` set.
- R12: Reads at any address change no word and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte address; bits [3:2] select the word |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Stored word at `bus_addr` |
| irq_event | input | 1 | Controller interrupt event pulse |
| irq_ack | input | 1 | Controller interrupt register was read |
| irq | output | 1 | Interrupt output |
| ctl_reset_req | output | 1 | One-cycle reset request to the controller |

## Verification
The assertions check on every cycle the per-write rules: the forced version nibble, the zero substitution, the loaded marker, the reset pulse, and the event and acknowledge effects on `irq` and the pending bit. Only the bench's scenarios can show that address aliasing works, that plain words keep their data, that reads have no effect, and how the three sources combine when they coincide. A reference model checks all of these over directed corners and a long seeded random run.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
    // control word bit positions
    localparam int PEND_BIT  = 0;
    localparam int IEN_BIT   = 4;
    localparam int FLUSH_BIT = 6;
    localparam int RST_BIT   = 7;
    // fixed codes
    localparam logic [3:0]  VER_CODE    = 4'hA;
    localparam logic [31:0] LOADED_CODE = 32'h0400_0000;
    localparam logic [31:0] ZERO_SUB    = 32'h0000_0040;
    // word roles
    localparam int CTRL_IDX = 0;
    localparam int ADDR_IDX = 1;
endpackage

// File: rtl/dma_chan_decode.sv
module dma_chan_decode #(
    parameter int ADDR_W    = 8,
    parameter int NUM_WORDS = 4,
    localparam int IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic              hit_ctrl,
    output logic              hit_addr,
    output logic              hit_plain
);
    import dma_chan_pkg::*;

    logic unused_addr_bits;

    assign idx = addr[IDX_W+1:2];

    generate
        if (ADDR_W > IDX_W + 2) begin : g_hi
            assign unused_addr_bits = ^{addr[ADDR_W-1:IDX_W+2], addr[1:0]};
        end else begin : g_nohi
            assign unused_addr_bits = ^addr[1:0];
        end
    endgenerate

    always_comb begin
        hit_ctrl  = we && (idx == IDX_W'(CTRL_IDX));
        hit_addr  = we && (idx == IDX_W'(ADDR_IDX));
        hit_plain = we && !hit_ctrl && !hit_addr;
    end
endmodule

// File: rtl/dma_chan_ctl_filter.sv
module dma_chan_ctl_filter #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] filt,
    output logic              rst_hit,
    output logic              ien_clear
);
    import dma_chan_pkg::*;

    logic [DATA_W-1:0] v;

    always_comb begin
        v = wdata;
        if (wdata == '0) begin
            v = DATA_W'(ZERO_SUB);
        end else if (!wdata[RST_BIT] && wdata[FLUSH_BIT]) begin
            v[FLUSH_BIT] = 1'b0;
        end
        filt      = {VER_CODE, v[DATA_W-5:0]};
        rst_hit   = wdata[RST_BIT];
        ien_clear = !wdata[IEN_BIT];
    end
endmodule

// File: rtl/dma_chan_ctl_next.sv
module dma_chan_ctl_next #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] ctrl_q,
    input  logic              irq_q,
    input  logic              hit_ctrl,
    input  logic              hit_addr,
    input  logic [DATA_W-1:0] filt,
    input  logic              ien_clear,
    input  logic              ack,
    input  logic              ev,
    output logic [DATA_W-1:0] ctrl_d,
    output logic              irq_d
);
    import dma_chan_pkg::*;

    always_comb begin
        // step 1: bus write result
        ctrl_d = ctrl_q;
        irq_d  = irq_q;
        if (hit_ctrl) begin
            ctrl_d = filt;
            if (ien_clear) irq_d = 1'b0;
        end else if (hit_addr) begin
            ctrl_d = DATA_W'(LOADED_CODE);
        end
        // step 2: acknowledge clears
        if (ack) begin
            ctrl_d[PEND_BIT] = 1'b0;
            irq_d            = 1'b0;
        end
        // step 3: event sets, last so it is never lost
        if (ev) begin
            ctrl_d[PEND_BIT] = 1'b1;
            irq_d            = 1'b1;
        end
    end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8,
    parameter int NUM_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              irq_event,
    input  logic              irq_ack,
    output logic              irq,
    output logic              ctl_reset_req
);
    import dma_chan_pkg::*;

    localparam int IDX_W = $clog2(NUM_WORDS);

    typedef struct packed {
        logic [NUM_WORDS-1:0][DATA_W-1:0] word;
        logic                             irq;
        logic                             rst_req;
    } state_t;

    state_t state_d, state_q;

    logic [IDX_W-1:0]  idx;
    logic              hit_ctrl, hit_addr, hit_plain;
    logic [DATA_W-1:0] filt;
    logic              rst_hit, ien_clear;
    logic [DATA_W-1:0] ctrl_next;
    logic              irq_next;
    logic [DATA_W-1:0] ctrl_word_q;

    dma_chan_decode #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_dec (
        .we        (bus_we),
        .addr      (bus_addr),
        .idx       (idx),
        .hit_ctrl  (hit_ctrl),
        .hit_addr  (hit_addr),
        .hit_plain (hit_plain)
    );

    dma_chan_ctl_filter #(.DATA_W(DATA_W)) u_filt (
        .wdata     (bus_wdata),
        .filt      (filt),
        .rst_hit   (rst_hit),
        .ien_clear (ien_clear)
    );

    dma_chan_ctl_next #(.DATA_W(DATA_W)) u_next (
        .ctrl_q    (state_q.word[CTRL_IDX]),
        .irq_q     (state_q.irq),
        .hit_ctrl  (hit_ctrl),
        .hit_addr  (hit_addr),
        .filt      (filt),
        .ien_clear (ien_clear),
        .ack       (irq_ack),
        .ev        (irq_event),
        .ctrl_d    (ctrl_next),
        .irq_d     (irq_next)
    );

    always_comb begin
        state_d         = state_q;
        state_d.rst_req = 1'b0;
        if (hit_ctrl && rst_hit) begin
            state_d.rst_req = 1'b1;
            for (int k = 1; k < NUM_WORDS; k++) begin
                state_d.word[k] = '0;
            end
        end
        if (hit_addr) begin
            state_d.word[ADDR_IDX] = bus_wdata;
        end
        if (hit_plain) begin
            state_d.word[idx] = bus_wdata;
        end
        state_d.word[CTRL_IDX] = ctrl_next;
        state_d.irq            = irq_next;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign bus_rdata     = state_q.word[idx];
    assign irq           = state_q.irq;
    assign ctl_reset_req = state_q.rst_req;
    assign ctrl_word_q   = state_q.word[CTRL_IDX];
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8,
    parameter int NUM_WORDS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq_event,
    input logic              irq_ack,
    input logic              irq,
    input logic              ctl_reset_req,
    input logic [DATA_W-1:0] ctrl_word_q
);
    localparam int IDX_W = $clog2(NUM_WORDS);

    logic [IDX_W-1:0] c_idx;
    logic             c_wctl, c_wadr;
    assign c_idx  = bus_addr[IDX_W+1:2];
    assign c_wctl = bus_we && (c_idx == '0);
    assign c_wadr = bus_we && (c_idx == IDX_W'(1));

    assert_nibble_R3: assert property (@(posedge clk) disable iff (!rst_n)
        c_wctl |=> (ctrl_word_q[DATA_W-1:DATA_W-4] == 4'hA));

    assert_reset_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (c_wctl && bus_wdata[7]) |=> ctl_reset_req);

    assert_reset_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(c_wctl && bus_wdata[7]) |=> !ctl_reset_req);

    assert_zero_sub_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (c_wctl && bus_wdata == '0 && !irq_event) |=> (ctrl_word_q == DATA_W'(32'hA000_0040)));

    assert_loaded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (c_wadr && !irq_event) |=> (ctrl_word_q == DATA_W'(32'h0400_0000)));

    assert_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_event |=> (irq && ctrl_word_q[0]));

    assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(irq_event));

    assert_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !irq_event) |=> (!irq && !ctrl_word_q[0]));

    assert_ien_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (c_wctl && !bus_wdata[4] && !irq_event) |=> !irq);
endmodule

bind dma_chan_regs dma_chan_regs_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_we        (bus_we),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .irq_event     (irq_event),
    .irq_ack       (irq_ack),
    .irq           (irq),
    .ctl_reset_req (ctl_reset_req),
    .ctrl_word_q   (ctrl_word_q)
);

// File: tb/dma_chan_regs_test.sv
module dma_chan_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_event = 1'b0;
    logic        irq_ack = 1'b0;
    logic        irq;
    logic        ctl_reset_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_w [4];
    logic        m_irq;
    logic        m_rst;

    always #2 clk = ~clk;

    dma_chan_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_event(irq_event),
        .irq_ack(irq_ack), .irq(irq), .ctl_reset_req(ctl_reset_req)
    );

    function automatic logic [31:0] ctl_rule(input logic [31:0] v);
        logic [31:0] r;
        r = v;
        if (v == 32'h0) r = 32'h40;
        else if (!v[7] && v[6]) r[6] = 1'b0;
        return (r & 32'h0FFF_FFFF) | 32'hA000_0000;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_step(input logic we, input logic [7:0] a, input logic [31:0] d,
                              input logic ev, input logic ak);
        int i;
        i = int'(a[3:2]);
        m_rst = we && (i == 0) && d[7];
        if (we) begin
            if (i == 0) begin
                m_w[0] = ctl_rule(d);
                if (d[7]) begin
                    m_w[1] = '0; m_w[2] = '0; m_w[3] = '0;
                end
                if (!d[4]) m_irq = 1'b0;
            end else if (i == 1) begin
                m_w[1] = d;
                m_w[0] = 32'h0400_0000;
            end else begin
                m_w[i] = d;
            end
        end
        if (ak) begin m_w[0][0] = 1'b0; m_irq = 1'b0; end
        if (ev) begin m_w[0][0] = 1'b1; m_irq = 1'b1; end
    endtask

    task automatic drive(input string tag, input logic we, input logic [7:0] a,
                         input logic [31:0] d, input logic ev, input logic ak);
        bus_we = we; bus_addr = a; bus_wdata = d; irq_event = ev; irq_ack = ak;
        @(posedge clk);
        model_step(we, a, d, ev, ak);
        #1;
        bus_we = 1'b0; irq_event = 1'b0; irq_ack = 1'b0;
        chk({tag, " irq"}, {31'h0, irq}, {31'h0, m_irq});
        chk({tag, " reset_req"}, {31'h0, ctl_reset_req}, {31'h0, m_rst});
    endtask

    task automatic rd(input string tag, input int i, input logic [3:0] hi, input logic [1:0] lo);
        bus_addr = {hi, i[1:0], lo};
        #0.5;
        chk({tag, " read"}, bus_rdata, m_w[i]);
    endtask

    task automatic rd_all(input string tag);
        for (int i = 0; i < 4; i++) rd(tag, i, 4'($urandom), 2'($urandom));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20241));
        for (int i = 0; i < 4; i++) m_w[i] = '0;
        m_irq = 1'b0; m_rst = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        rd_all("R1");
        chk("R1 irq", {31'h0, irq}, 32'h0);
        chk("R1 reset_req", {31'h0, ctl_reset_req}, 32'h0);
        // R2 plain words and aliasing
        drive("R2", 1, 8'h08, 32'h1234_5678, 0, 0);
        drive("R2", 1, 8'hFC, 32'hCAFE_F00D, 0, 0);
        rd("R2", 2, 4'h7, 2'h3);
        rd("R2", 3, 4'h0, 2'h0);
        // R3 forced nibble
        drive("R3", 1, 8'h00, 32'h5000_0010, 0, 0);
        rd("R3", 0, 4'h0, 2'h0);
        // R5 flush dropped
        drive("R5", 1, 8'h40, 32'h0000_0050, 0, 0);
        rd("R5", 0, 4'h0, 2'h0);
        // R6 zero write
        drive("R6", 1, 8'h00, 32'h0, 0, 0);
        rd("R6", 0, 4'h0, 2'h0);
        // R4 reset request
        drive("R4", 1, 8'h01, 32'h0000_00C0, 0, 0);
        rd_all("R4");
        drive("R4 end", 0, 8'h00, 32'h0, 0, 0);
        // R7 loaded marker
        drive("R7", 1, 8'h04, 32'hDEAD_BEEF, 0, 0);
        rd("R7", 0, 4'h0, 2'h0);
        rd("R7", 1, 4'h0, 2'h0);
        // R8 event
        drive("R8", 0, 8'h00, 32'h0, 1, 0);
        rd("R8", 0, 4'h0, 2'h0);
        // R12 reads have no effect
        rd_all("R12");
        rd_all("R12");
        drive("R12", 0, 8'h08, 32'hFFFF_FFFF, 0, 0);
        rd_all("R12");
        // R9 ack
        drive("R9", 0, 8'h00, 32'h0, 0, 1);
        rd("R9", 0, 4'h0, 2'h0);
        // R10 interrupt enable
        drive("R10 set", 0, 8'h00, 32'h0, 1, 0);
        drive("R10 ien", 1, 8'h00, 32'h0000_0010, 0, 0);
        rd("R10", 0, 4'h0, 2'h0);
        drive("R10 noien", 1, 8'h00, 32'h0000_0001, 0, 0);
        rd("R10", 0, 4'h0, 2'h0);
        // R11 merges
        drive("R11 ev+ack", 0, 8'h00, 32'h0, 1, 1);
        rd("R11", 0, 4'h0, 2'h0);
        drive("R11 ev+ctl", 1, 8'h00, 32'h0000_0020, 1, 0);
        rd("R11", 0, 4'h0, 2'h0);
        drive("R11 ev+adr", 1, 8'h04, 32'h0000_1000, 1, 0);
        rd("R11", 0, 4'h0, 2'h0);
        drive("R11 ack+ctl", 1, 8'h00, 32'h0000_0031, 0, 1);
        rd("R11", 0, 4'h0, 2'h0);
        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] d;
            logic [7:0] a;
            int sel;
            sel = int'($urandom_range(0, 9));
            d = $urandom;
            if (sel == 0) d = 32'h0;
            else if (sel == 1) d = d & 32'h0000_00FF;
            a = 8'($urandom);
            drive("R11 random", ($urandom_range(0, 2) != 0), a, d,
                  ($urandom_range(0, 5) == 0), ($urandom_range(0, 5) == 0));
            rd("R2 random", int'($urandom_range(0, 3)), 4'($urandom), 2'($urandom));
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule